// File: doc/BRIEF.md
# Parallel Bus Source Handshake

This block is the sending end of a byte transfer on an 8-bit parallel instrument bus whose receivers share two open-collector status lines. A local producer offers a byte over a valid/ready interface. The block puts the byte on the data lines and waits a programmable number of setup clocks. It then asserts the data-valid strobe, but only when every receiver reports that it is ready and none still holds the previous byte. It keeps the strobe asserted until every receiver reports that it has accepted the byte. After that it withdraws the strobe first and the data afterwards.

All bus lines are negative-true. A low level means asserted. The block models each line it drives as a drive-low enable: a 1 pulls the line low. It reads the two shared status lines as raw levels and passes each one through a two-flop synchroniser. Along with each byte it drives an attention line, which marks the byte as an interface command, and an end line, which marks the last data byte of a message. If the ready line and the accepted line are both sensed high at the same time, no receiver is pulling either line low. The block reports this as an absent-listener condition.

Top module: `pbus_src`

## Requirements
- R1: In reset and whenever the block is idle: `in_ready` is 1, and `dav_drv`, `atn_drv`, `eoi_drv` and every bit of `dio_drv` are 0, so all driven lines are released (high). `no_listener` is 0 in reset.
- R2: A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` is 0 and `dio_drv` equals the byte. A data value of 1 in bit i pulls data line i low.
- R3: `dio_drv` does not change while `dav_drv` is 1, nor in the cycle right after `dav_drv` returns to 0. In the cycle after that it returns to 0.
- R4: `dav_drv` rises only after two conditions hold. First, `dio_drv` has been driven for at least `setup_clks`+1 cycles. Second, the synchronised ready line is high and the synchronised accepted line is low. A level presented before clock edge E first affects `dav_drv` after edge E+2.
- R5: While `dav_drv` is 1, an accepted line sampled high at edge E clears `dav_drv` after edge E+2. The byte stays on `dio_drv` for one more cycle, and then `in_ready` returns to 1.
- R6: A byte taken with `in_cmd`=1 keeps `atn_drv` at 1 for its whole drive window. A byte taken with `in_cmd`=0 keeps `atn_drv` at 0.
- R7: `eoi_drv` is 1 for the whole drive window of a byte taken with `in_last`=1 and `in_cmd`=0. It stays 0 for command bytes and for bytes that are not last.
- R8: `no_listener` is a registered level. It equals the AND of the synchronised ready and accepted lines, so a pair of levels sampled at edge E shows after edge E+2, both when idle and during a transfer.
- R9: The slowest receiver sets the pace. `dav_drv` stays 1 for as long as the accepted line stays low. `dav_drv` stays 0 for as long as the ready line stays low, however long the setup time has been.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Block is idle and will take a byte |
| in_data | input | DW | Byte to send |
| in_cmd | input | 1 | Byte is an interface command |
| in_last | input | 1 | Byte ends a data message |
| setup_clks | input | SW | Minimum extra setup clocks before the strobe |
| dio_drv | output | DW | Drive-low enables for the data lines |
| dav_drv | output | 1 | Drive-low enable for the data-valid strobe |
| atn_drv | output | 1 | Drive-low enable for the attention line |
| eoi_drv | output | 1 | Drive-low enable for the end line |
| nrfd_in | input | 1 | Sensed level of the shared not-ready line |
| ndac_in | input | 1 | Sensed level of the shared not-accepted line |
| no_listener | output | 1 | Ready and accepted lines sensed high together |

## Verification
Two events can land on the same clock edge: the strobe release caused by an acceptance (R5) and the absent-listener flag (R8). Both depend on the same synchronised accepted line. The bench provokes this by raising the accepted line while the ready line is still high and the strobe is asserted. A behavioural model updated on every edge must then show the strobe released and the flag set on the same sample, three falling edges after the change. The bench also paces bytes through a listener model with zero and with long delays, and checks that the captured bytes carry the expected attention and end markings.

// File: rtl/pbus_src.sv
module pbus_src #(
  parameter int DW = 8,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_cmd,
  input  logic          in_last,
  input  logic [SW-1:0] setup_clks,
  output logic [DW-1:0] dio_drv,
  output logic          dav_drv,
  output logic          atn_drv,
  output logic          eoi_drv,
  input  logic          nrfd_in,
  input  logic          ndac_in,
  output logic          no_listener
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_VALID, S_HOLD} state_t;

  state_t        state;
  logic [1:0]    rdy_sync, acc_sync;
  logic [SW-1:0] cnt;
  logic [DW-1:0] byte_q;
  logic          cmd_q, last_q;

  wire rdy_s    = rdy_sync[1];
  wire acc_s    = acc_sync[1];
  wire busy     = (state != S_IDLE);
  wire setup_ok = (cnt >= setup_clks);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_sync    <= '0;
      acc_sync    <= '0;
      no_listener <= 1'b0;
    end else begin
      rdy_sync    <= {rdy_sync[0], nrfd_in};
      acc_sync    <= {acc_sync[0], ndac_in};
      no_listener <= rdy_s & acc_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      byte_q <= '0;
      cmd_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (in_valid) begin
            byte_q <= in_data;
            cmd_q  <= in_cmd;
            last_q <= in_last;
            cnt    <= '0;
            state  <= S_SETUP;
          end
        S_SETUP:
          if (setup_ok && rdy_s && !acc_s) state <= S_VALID;
          else if (!setup_ok)              cnt   <= cnt + 1'b1;
        S_VALID:
          if (acc_s) state <= S_HOLD;
        default:
          state <= S_IDLE;
      endcase
    end
  end

  assign in_ready = !busy;
  assign dio_drv  = busy ? byte_q : '0;
  assign dav_drv  = (state == S_VALID);
  assign atn_drv  = busy & cmd_q;
  assign eoi_drv  = busy & last_q & ~cmd_q;

endmodule

// File: rtl/pbus_src_chk.sv
module pbus_src_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic [DW-1:0] dio_drv,
  input logic          dav_drv,
  input logic          atn_drv,
  input logic          eoi_drv,
  input logic          nrfd_in,
  input logic          ndac_in,
  input logic          no_listener
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!dav_drv && !atn_drv && !eoi_drv && dio_drv == '0));

  assert_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dav_drv |-> $stable(dio_drv));

  assert_data_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_drv) |-> $stable(dio_drv));

  assert_markers_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_drv) |-> ($stable(atn_drv) && $stable(eoi_drv)));

  assert_end_not_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_drv |-> !atn_drv);

  assert_release_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_drv) |-> $past(ndac_in, 3));

  assert_strobe_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_drv) |-> ($past(nrfd_in, 3) && !$past(ndac_in, 3)));

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    no_listener |-> ($past(nrfd_in, 3) && $past(ndac_in, 3)));

endmodule

bind pbus_src pbus_src_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .dio_drv(dio_drv),
  .dav_drv(dav_drv), .atn_drv(atn_drv), .eoi_drv(eoi_drv),
  .nrfd_in(nrfd_in), .ndac_in(ndac_in), .no_listener(no_listener)
);

// File: tb/tb_pbus_src.sv
module tb_pbus_src;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_cmd = 1'b0;
  logic       in_last = 1'b0;
  logic [5:0] setup_clks = '0;
  logic [7:0] dio_drv;
  logic       dav_drv, atn_drv, eoi_drv, no_listener;
  logic       nrfd_in = 1'b0;
  logic       ndac_in = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pbus_src dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_cmd(in_cmd), .in_last(in_last),
    .setup_clks(setup_clks), .dio_drv(dio_drv), .dav_drv(dav_drv),
    .atn_drv(atn_drv), .eoi_drv(eoi_drv), .nrfd_in(nrfd_in),
    .ndac_in(ndac_in), .no_listener(no_listener)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, updated on each rising edge
  bit   hn[2], ha[2];
  int   ph = 0;
  int   mcnt = 0;
  logic [7:0] mbyte = '0;
  bit   mcmd = 0, mlast = 0, merr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hn[0] = 0; hn[1] = 0; ha[0] = 0; ha[1] = 0;
      ph = 0; mcnt = 0; merr = 0;
    end else begin
      bit nerr;
      nerr = hn[1] && ha[1];
      case (ph)
        0: if (in_valid) begin
             mbyte = in_data; mcmd = in_cmd; mlast = in_last; mcnt = 0; ph = 1;
           end
        1: if (mcnt >= int'(setup_clks) && hn[1] && !ha[1]) ph = 2;
           else if (mcnt < int'(setup_clks)) mcnt++;
        2: if (ha[1]) ph = 3;
        default: ph = 0;
      endcase
      merr = nerr;
      hn[1] = hn[0]; hn[0] = nrfd_in;
      ha[1] = ha[0]; ha[0] = ndac_in;
    end
  end

  // Per-cycle comparison and ordering monitor
  logic [7:0] prev_dio = '0;
  bit prev_dav = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e;
      e = 0;
      if (in_ready !== (ph == 0)) begin
        e++; $display("FAIL R2: in_ready actual=%0b expected=%0b", in_ready, ph == 0);
      end
      if (dio_drv !== ((ph != 0) ? mbyte : 8'h00)) begin
        e++; $display("FAIL R2: dio_drv actual=%0h expected=%0h", dio_drv, (ph != 0) ? mbyte : 8'h00);
      end
      if (dav_drv !== (ph == 2)) begin
        e++; $display("FAIL R4: dav_drv actual=%0b expected=%0b", dav_drv, ph == 2);
      end
      if (atn_drv !== (ph != 0 && mcmd)) begin
        e++; $display("FAIL R6: atn_drv actual=%0b expected=%0b", atn_drv, ph != 0 && mcmd);
      end
      if (eoi_drv !== (ph != 0 && mlast && !mcmd)) begin
        e++; $display("FAIL R7: eoi_drv actual=%0b expected=%0b", eoi_drv, ph != 0 && mlast && !mcmd);
      end
      if (no_listener !== merr) begin
        e++; $display("FAIL R8: no_listener actual=%0b expected=%0b", no_listener, merr);
      end
      checks++;
      if (e != 0) errors++;
      if (prev_dav || dav_drv) check("R3 data stable around strobe", dio_drv, prev_dio);
      prev_dav = dav_drv;
      prev_dio = dio_drv;
    end
  end

  // Listener model: auto mode with a delay, or manual control
  bit auto_mode = 0;
  int lag = 0;
  int ls = 0, lc = 0;
  logic [9:0] rxq[$];
  always @(negedge clk) begin
    if (auto_mode) begin
      case (ls)
        0: if (dav_drv) begin
             if (lc >= lag) begin
               rxq.push_back({atn_drv, eoi_drv, dio_drv});
               nrfd_in = 0; ndac_in = 1; ls = 1; lc = 0;
             end else lc++;
           end
        1: if (!dav_drv) begin ndac_in = 0; ls = 2; end
        default: if (lc >= lag) begin nrfd_in = 1; ls = 0; lc = 0; end else lc++;
      endcase
    end
  end

  task automatic send(input logic [7:0] b, input bit c, input bit l);
    @(negedge clk);
    in_valid = 1; in_data = b; in_cmd = c; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_idle;
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  logic [9:0] expq[$];
  task automatic send_auto(input logic [7:0] b, input bit c, input bit l);
    expq.push_back({c, l & ~c, b});
    send(b, c, l);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 in_ready in reset", in_ready, 1);
    check("R1 dav_drv in reset", dav_drv, 0);
    check("R1 dio_drv in reset", dio_drv, 0);
    check("R1 no_listener in reset", no_listener, 0);
    rst_n = 1;

    // Auto listener, no delay, no setup
    nrfd_in = 1; ndac_in = 0; auto_mode = 1; lag = 0; setup_clks = 0;
    repeat (3) @(negedge clk);
    send_auto(8'hA5, 0, 0);
    send_auto(8'h3C, 0, 0);
    send_auto(8'hFF, 0, 1);
    wait_idle();
    // Slow listener, longer setup, command bytes
    lag = 6; setup_clks = 4;
    send_auto(8'h21, 1, 0);
    send_auto(8'h3F, 1, 1);
    send_auto(8'h00, 0, 1);
    wait_idle();
    repeat (10) @(negedge clk);
    check("R2 byte count", rxq.size(), expq.size());
    while (rxq.size() > 0 && expq.size() > 0) begin
      logic [9:0] a, x;
      a = rxq.pop_front(); x = expq.pop_front();
      check("R2 byte on data lines", a[7:0], x[7:0]);
      check("R6 attention marking", a[9], x[9]);
      check("R7 end marking", a[8], x[8]);
    end

    // Manual listener: ready held off (R4, R9)
    auto_mode = 0; nrfd_in = 0; ndac_in = 0; setup_clks = 2;
    repeat (4) @(negedge clk);
    send(8'h5A, 0, 0);
    repeat (10) @(negedge clk);
    check("R9 strobe held off while not ready", dav_drv, 0);
    check("R2 byte driven while waiting", dio_drv, 8'h5A);
    nrfd_in = 1;
    @(negedge clk);
    @(negedge clk);
    check("R4 strobe not yet after two edges", dav_drv, 0);
    @(negedge clk);
    check("R4 strobe after sync latency", dav_drv, 1);
    nrfd_in = 0;
    repeat (20) @(negedge clk);
    check("R9 strobe held until accepted", dav_drv, 1);
    ndac_in = 1;
    @(negedge clk);
    @(negedge clk);
    check("R5 strobe still held two edges after accept", dav_drv, 1);
    @(negedge clk);
    check("R5 strobe released", dav_drv, 0);
    check("R3 data held one cycle after release", dio_drv, 8'h5A);
    @(negedge clk);
    check("R3 data released", dio_drv, 0);
    check("R5 ready again", in_ready, 1);
    ndac_in = 0; nrfd_in = 1;
    repeat (4) @(negedge clk);

    // Same cycle: accept with ready still high -> release and flag together
    send(8'hC3, 1, 0);
    while (!dav_drv) @(negedge clk);
    ndac_in = 1;
    @(negedge clk);
    @(negedge clk);
    check("R8 flag not yet", no_listener, 0);
    @(negedge clk);
    check("R5 release together with flag", dav_drv, 0);
    check("R8 flag together with release", no_listener, 1);
    ndac_in = 0;
    repeat (3) @(negedge clk);
    check("R8 flag clears", no_listener, 0);

    // Idle flag with both lines high
    repeat (3) @(negedge clk);
    nrfd_in = 1; ndac_in = 1;
    repeat (3) @(negedge clk);
    check("R8 flag while idle", no_listener, 1);
    check("R1 idle lines released", dav_drv | atn_drv | eoi_drv, 0);
    ndac_in = 0;
    repeat (3) @(negedge clk);
    check("R8 flag cleared while idle", no_listener, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule